// File: doc/BRIEF.md
# Dual-Purpose Flag and Sync Pin Conditioner

This block serves two pins that each carry one of two functions. The input pin carries either a frequency-sync reference or a fault/status flag. In flag mode it can be inverted and can be debounced over a long stability window. The output pin carries either the sync signal produced elsewhere in the chip or one of two light-load flags, and a polarity bit can invert that flag.

The raw input pin passes through a two-flop synchronizer. In flag mode the synchronized level is inverted if required, then goes to a stability filter that either passes it after one register or holds it until the new level has stayed unchanged for `DEBOUNCE_CYCLES` clocks. At 25 MHz the default of 2500 cycles gives 100 µs. Each output is forced low while its pin serves the other function. The output pin is a purely combinational selection.

Top module: `flagsync_pin_cond`

## Requirements
- R1: After reset, with the input pin held low and no configuration changes, `flag_in` and `sync_in` are low.
- R2: With `in_is_flag`=0, `sync_in` follows `pin_in` two clock edges after the pin changes, and `flag_in` stays low.
- R3: With `in_is_flag`=1, `sync_in` is low. `flag_in` is asserted when the pin is high if `in_invert`=0, and when the pin is low if `in_invert`=1.
- R4: With `in_debounce_en`=0, a change of the (polarity-adjusted) pin level reaches `flag_in` on the third clock edge after the pin changes.
- R5: With `in_debounce_en`=1, a new pin level is accepted only after it has been seen on `DEBOUNCE_CYCLES` consecutive edges. `flag_in` changes on edge `DEBOUNCE_CYCLES`+2 after the pin changes, counting the two synchronizer edges.
- R6: Any return of the level to the accepted value during the stability window restarts the window.
- R7: With `out_is_flag`=0, `pin_out` equals `sync_src` in the same cycle.
- R8: With `out_is_flag`=1, `pin_out` is `lightload_a` when `out_flag_sel_b`=0 and `lightload_b` when it is 1. `out_invert`=1 inverts that value.
- R9: Changing `in_is_flag` gates the outputs in the same cycle. The filtered flag state is kept and continues to update while the pin is in sync mode, so it reappears on `flag_in` when flag mode returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_in | input | 1 | Raw level of the dual-purpose input pin |
| sync_src | input | 1 | Sync signal to place on the output pin |
| lightload_a | input | 1 | Light-load flag, channel A |
| lightload_b | input | 1 | Light-load flag, channel B |
| in_is_flag | input | 1 | 0: input pin is sync, 1: input pin is flag |
| in_invert | input | 1 | Input flag active low when 1 |
| in_debounce_en | input | 1 | 1: apply the stability window |
| out_is_flag | input | 1 | 0: output pin is sync, 1: output pin is flag |
| out_flag_sel_b | input | 1 | Flag source, 0: channel A, 1: channel B |
| out_invert | input | 1 | Invert the output flag when 1 |
| sync_in | output | 1 | Synchronized sync input, low in flag mode |
| flag_in | output | 1 | Filtered flag input, low in sync mode |
| pin_out | output | 1 | Level driven onto the output pin |

## Verification
Two events can fall in the same cycle: the edge at which the stability window accepts a new flag level, and a switch of the input pin to sync mode. The bench brings the window to one edge before acceptance and changes `in_is_flag` just before that edge. It then expects `flag_in` low and `sync_in` high right after the edge, and `flag_in` high as soon as flag mode is restored with no further edge. The output mux is swept over all 64 combinations of its inputs. The input path is swept over mode, polarity and pin level, with the expected values computed from these rules.

// File: rtl/flagsync_pin_cond.sv
module flagsync_pin_cond #(
  parameter int SYNC_STAGES     = 2,
  parameter int DEBOUNCE_CYCLES = 2500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_in,
  input  logic sync_src,
  input  logic lightload_a,
  input  logic lightload_b,
  input  logic in_is_flag,
  input  logic in_invert,
  input  logic in_debounce_en,
  input  logic out_is_flag,
  input  logic out_flag_sel_b,
  input  logic out_invert,
  output logic sync_in,
  output logic flag_in,
  output logic pin_out
);
  localparam int CW = $clog2(DEBOUNCE_CYCLES + 1);

  logic [SYNC_STAGES-1:0] sy;
  logic [CW-1:0]          cnt;
  logic                   flag_state;
  logic                   pin_s, lvl;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sy <= '0;
    else        sy <= {sy[SYNC_STAGES-2:0], pin_in};

  assign pin_s = sy[SYNC_STAGES-1];
  assign lvl   = pin_s ^ in_invert;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_state <= 1'b0;
      cnt        <= '0;
    end else if (!in_debounce_en) begin
      flag_state <= lvl;
      cnt        <= '0;
    end else if (lvl == flag_state) begin
      cnt <= '0;
    end else if (cnt == CW'(DEBOUNCE_CYCLES - 1)) begin
      flag_state <= lvl;
      cnt        <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assign flag_in = in_is_flag & flag_state;
  assign sync_in = ~in_is_flag & pin_s;
  assign pin_out = out_is_flag ? ((out_flag_sel_b ? lightload_b : lightload_a) ^ out_invert)
                               : sync_src;
endmodule

// File: rtl/flagsync_pin_cond_chk.sv
module flagsync_pin_cond_chk (
  input logic clk,
  input logic rst_n,
  input logic sync_src,
  input logic lightload_a,
  input logic lightload_b,
  input logic in_is_flag,
  input logic out_is_flag,
  input logic out_flag_sel_b,
  input logic out_invert,
  input logic sync_in,
  input logic flag_in,
  input logic pin_out
);
  a_r2_flag_low_in_sync: assert property (@(posedge clk) disable iff (!rst_n)
    !in_is_flag |-> !flag_in);
  a_r3_sync_low_in_flag: assert property (@(posedge clk) disable iff (!rst_n)
    in_is_flag |-> !sync_in);
  a_r7_out_sync: assert property (@(posedge clk) disable iff (!rst_n)
    !out_is_flag |-> pin_out == sync_src);
  a_r8_out_a: assert property (@(posedge clk) disable iff (!rst_n)
    out_is_flag && !out_flag_sel_b && !out_invert |-> pin_out == lightload_a);
  a_r8_out_b_inv: assert property (@(posedge clk) disable iff (!rst_n)
    out_is_flag && out_flag_sel_b && out_invert |-> pin_out != lightload_b);
endmodule

bind flagsync_pin_cond flagsync_pin_cond_chk chk_i (
  .clk(clk), .rst_n(rst_n), .sync_src(sync_src), .lightload_a(lightload_a),
  .lightload_b(lightload_b), .in_is_flag(in_is_flag), .out_is_flag(out_is_flag),
  .out_flag_sel_b(out_flag_sel_b), .out_invert(out_invert), .sync_in(sync_in),
  .flag_in(flag_in), .pin_out(pin_out)
);

// File: tb/flagsync_pin_cond_tb_top.sv
module flagsync_pin_cond_tb_top;
  localparam int DB = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic pin_in = 0, sync_src = 0, lightload_a = 0, lightload_b = 0;
  logic in_is_flag = 0, in_invert = 0, in_debounce_en = 0;
  logic out_is_flag = 0, out_flag_sel_b = 0, out_invert = 0;
  logic sync_in, flag_in, pin_out;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  flagsync_pin_cond #(.SYNC_STAGES(2), .DEBOUNCE_CYCLES(DB)) dut_i (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .sync_src(sync_src),
    .lightload_a(lightload_a), .lightload_b(lightload_b), .in_is_flag(in_is_flag),
    .in_invert(in_invert), .in_debounce_en(in_debounce_en), .out_is_flag(out_is_flag),
    .out_flag_sel_b(out_flag_sel_b), .out_invert(out_invert),
    .sync_in(sync_in), .flag_in(flag_in), .pin_out(pin_out));

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    tick(2);
    rst_n = 1'b1;
    tick(3);
    chk("R1 flag_in", flag_in, 1'b0);
    chk("R1 sync_in", sync_in, 1'b0);

    // R7 R8: output mux, exhaustive
    for (int v = 0; v < 64; v++) begin
      {out_is_flag, out_flag_sel_b, out_invert, lightload_a, lightload_b, sync_src} = 6'(v);
      #1;
      if (!out_is_flag) chk("R7 pin_out", pin_out, sync_src);
      else chk("R8 pin_out", pin_out,
               (out_flag_sel_b ? lightload_b : lightload_a) ^ out_invert);
    end

    // R2 timing: sync follows after two edges
    in_is_flag = 0; pin_in = 1;
    tick(1);
    chk("R2 sync_in before", sync_in, 1'b0);
    tick(1);
    chk("R2 sync_in after", sync_in, 1'b1);
    pin_in = 0; tick(3);

    // R2 R3: input sweep, no debounce
    for (int v = 0; v < 8; v++) begin
      {in_is_flag, in_invert, pin_in} = 3'(v);
      tick(4);
      chk(in_is_flag ? "R3 flag_in" : "R2 flag_in", flag_in, in_is_flag & (pin_in ^ in_invert));
      chk(in_is_flag ? "R3 sync_in" : "R2 sync_in", sync_in, ~in_is_flag & pin_in);
    end

    // R4: flag latency without debounce
    in_is_flag = 1; in_invert = 0; pin_in = 0; tick(4);
    pin_in = 1;
    tick(2);
    chk("R4 flag_in before", flag_in, 1'b0);
    tick(1);
    chk("R4 flag_in after", flag_in, 1'b1);
    pin_in = 0; tick(4);

    // R5: debounce window
    in_debounce_en = 1; tick(2);
    pin_in = 1;
    tick(DB + 1);
    chk("R5 flag_in before", flag_in, 1'b0);
    tick(1);
    chk("R5 flag_in after", flag_in, 1'b1);
    pin_in = 0;
    tick(DB + 1);
    chk("R5 release before", flag_in, 1'b1);
    tick(1);
    chk("R5 release after", flag_in, 1'b0);

    // R6: bounce restarts the window
    pin_in = 1; tick(DB - 2);
    pin_in = 0; tick(1);
    pin_in = 1;
    tick(DB + 1);
    chk("R6 flag_in before", flag_in, 1'b0);
    tick(1);
    chk("R6 flag_in after", flag_in, 1'b1);
    pin_in = 0; tick(DB + 4);
    chk("R6 cleared", flag_in, 1'b0);

    // R9: acceptance coincides with a switch to sync mode
    pin_in = 1;
    tick(DB + 1);
    in_is_flag = 0;
    tick(1);
    chk("R9 flag_in gated", flag_in, 1'b0);
    chk("R9 sync_in live", sync_in, 1'b1);
    in_is_flag = 1; #1;
    chk("R9 flag_in kept", flag_in, 1'b1);
    chk("R9 sync_in gated", sync_in, 1'b0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule